// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a logical address into its final page descriptor by fetching one descriptor from each of three tables in memory: a root table, a pointer table and a page table. It runs as a sequential state machine. The table base comes from one of two root pointers, and the choice depends on whether the access is privileged. Each level reads one 32-bit word. Root and pointer descriptors are then checked for validity. A page descriptor may be an indirect link, and in that case the walker follows it once. The walker collects write-protect bits across the levels. It also writes back the usage-tracking flags in the descriptors it has touched.

A requester offers a walk on a valid/ready handshake. `req_ready` is high only while the walker is idle, so a requester that holds `req_valid` is simply stalled until the current walk ends. The result comes back as a one-cycle `done` pulse, together with the descriptor and a fault flag. Memory is reached through a single word port. The walker raises `mem_req` and keeps address, direction and write data steady until the memory answers with `mem_ready`. Read data and the error flag are sampled in that same cycle. Memory back-pressure is simply wait states on `mem_ready`.

Top module: `ptw_walker`

## Requirements
- R1: A walk starts only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when idle, and the idle walker drives no memory request. A `req_valid` pulse during a walk starts nothing and produces no extra `done`.
- R2: The walk begins from `root_super` when `req_super` is 1 and from `root_user` otherwise.
- R3: The root descriptor address is `(root & 0xFFFFFE00) | ((addr >> 23) & 0x1FC)`. The pointer descriptor address is `(rootdesc & 0xFFFFFE00) | ((addr >> 16) & 0x1FC)`.
- R4: The page descriptor address is `(ptrdesc & 0xFFFFFF00) | ((addr >> 10) & 0xFC)` when `req_big_page` is 0 (4 KiB pages). It is `(ptrdesc & 0xFFFFFF80) | ((addr >> 11) & 0x7C)` when `req_big_page` is 1 (8 KiB pages).
- R5: A root or pointer descriptor with bit 1 clear ends the walk at once, with descriptor 0 and fault 1. No further memory access follows.
- R6: A page descriptor whose bits [1:0] equal 2'b10 is a link. The word at `(link & 0xFFFFFFFC)` is read once and is treated as the page descriptor, whatever its low bits. Write-back then goes to the linked word, and the link entry is left untouched.
- R7: A page descriptor with bit 0 clear is returned exactly as read, with fault 1 and no write-back.
- R8: A root or pointer descriptor with the used bit (bit 3) clear is written back to its own address with bit 3 set, before the next level is read.
- R9: The write-protect bits (bit 2) of the root, pointer and page descriptors are ORed together into bit 2 of the returned descriptor.
- R10: For a resident page, the walker sets used (bit 3). On a write to a page that is not protected under R9, it also sets modified (bit 4). The word is written back only if this changes it. The value written is the fetched descriptor plus these flags, without the inherited write-protect bit.
- R11: A read that completes with `mem_err` high ends the walk with descriptor 0 and fault 1, on the next cycle.
- R12: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R13: `done` is high for exactly one cycle per walk. `fault` equals the inverse of bit 0 of `desc_out`. Both outputs hold until the next walk completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_addr | input | 32 | Logical address to translate |
| req_super | input | 1 | Privileged access, selects the supervisor root |
| req_write | input | 1 | Access is a write |
| req_big_page | input | 1 | 1 = 8 KiB pages, 0 = 4 KiB pages |
| root_user | input | 32 | Root table pointer for unprivileged accesses |
| root_super | input | 32 | Root table pointer for privileged accesses |
| done | output | 1 | One-cycle completion pulse |
| desc_out | output | 32 | Final descriptor, or 0 on a broken walk |
| fault | output | 1 | Translation unusable (bit 0 of `desc_out` clear) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write-back data |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_err | input | 1 | Read error, valid with `mem_ready` |

## Verification
The assertions check on every cycle the properties that hold at all times:
- the single-cycle `done` pulse;
- the quiet memory port while idle;
- the refusal of new work once busy;
- stable request signals under memory wait states;
- the used bit present in every write-back;
- the zero result that follows a read error.

The walk contents can only be shown by the bench's scenarios, which compare the design against a behavioural model of the tables. These include the address each level reads, the link indirection, the accumulated write protection, the exact words written back and the final descriptor. The scenarios cover both page sizes, both root pointers, broken and non-resident entries, and memory latencies of zero and several cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int DESC_W    = 32;
  localparam int WORD_LSB  = 2;
  localparam int UP_IDX_W  = 7;    // entries per root/pointer table = 2**UP_IDX_W
  localparam int SMALL_PAGE_SHIFT = 12;

  localparam int ROOT_LO     = VA_W - UP_IDX_W;
  localparam int PTR_LO      = ROOT_LO - UP_IDX_W;
  localparam int UP_TBL_LSB  = UP_IDX_W + WORD_LSB;
  localparam int PG_IDX_SMALL = PTR_LO - SMALL_PAGE_SHIFT;
  localparam int PG_IDX_BIG   = PG_IDX_SMALL - 1;
  localparam int PG_TBL_LSB_SMALL = PG_IDX_SMALL + WORD_LSB;
  localparam int PG_TBL_LSB_BIG   = PG_IDX_BIG + WORD_LSB;

  // descriptor bit positions
  localparam int B_RES   = 0;
  localparam int B_LINK  = 1;
  localparam int B_WP    = 2;
  localparam int B_USED  = 3;
  localparam int B_DIRTY = 4;
  localparam logic [1:0] IND_CODE = 2'b10;
  localparam logic [DESC_W-1:0] USED_MASK = DESC_W'(1) << B_USED;

  typedef enum logic [1:0] {LV_ROOT, LV_PTR, LV_PAGE, LV_IND} lvl_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ROOT, S_WB_ROOT, S_RD_PTR, S_WB_PTR,
    S_RD_PAGE, S_RD_IND, S_WB_PAGE, S_DONE
  } st_e;
endpackage

// File: rtl/ptw_index.sv
module ptw_index
  import ptw_pkg::*;
(
  input  lvl_e                              lvl,
  input  logic [VA_W-1:SMALL_PAGE_SHIFT]    vpn,
  input  logic                              big_page,
  input  logic [DESC_W-1:WORD_LSB]          base,
  output logic [VA_W-1:0]                   addr
);
  always_comb begin
    unique case (lvl)
      LV_ROOT: addr = {base[DESC_W-1:UP_TBL_LSB], vpn[VA_W-1:ROOT_LO], {WORD_LSB{1'b0}}};
      LV_PTR:  addr = {base[DESC_W-1:UP_TBL_LSB], vpn[ROOT_LO-1:PTR_LO], {WORD_LSB{1'b0}}};
      LV_PAGE: begin
        if (big_page)
          addr = {base[DESC_W-1:PG_TBL_LSB_BIG], vpn[PTR_LO-1:SMALL_PAGE_SHIFT+1],
                  {WORD_LSB{1'b0}}};
        else
          addr = {base[DESC_W-1:PG_TBL_LSB_SMALL], vpn[PTR_LO-1:SMALL_PAGE_SHIFT],
                  {WORD_LSB{1'b0}}};
      end
      default: addr = {base, {WORD_LSB{1'b0}}};
    endcase
  end
endmodule

// File: rtl/ptw_flags.sv
module ptw_flags
  import ptw_pkg::*;
(
  input  logic [DESC_W-1:0] pg,
  input  logic              inh_wp,
  input  logic              is_write,
  output logic              resident,
  output logic              need_wb,
  output logic [DESC_W-1:0] wb_val,
  output logic [DESC_W-1:0] res_val
);
  logic prot;

  always_comb begin
    prot     = pg[B_WP] | inh_wp;
    resident = pg[B_RES];
    wb_val   = pg;
    wb_val[B_USED] = 1'b1;
    if (is_write && !prot) wb_val[B_DIRTY] = 1'b1;
    need_wb  = (wb_val != pg);
    res_val  = wb_val;
    res_val[B_WP] = prot;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_addr,
  input  logic              req_super,
  input  logic              req_write,
  input  logic              req_big_page,
  input  logic [DESC_W-1:0] root_user,
  input  logic [DESC_W-1:0] root_super,
  output logic              done,
  output logic [DESC_W-1:0] desc_out,
  output logic              fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic [VA_W-1:0]   mem_addr,
  output logic [DESC_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DESC_W-1:0] mem_rdata,
  input  logic              mem_err
);
  st_e                           st;
  logic [VA_W-1:SMALL_PAGE_SHIFT] vpn_q;
  logic                          wr_q;
  logic                          big_q;
  logic                          wp_q;
  logic [DESC_W-1:WORD_LSB]      base_q;
  logic [VA_W-1:0]               wb_addr_q;
  logic [DESC_W-1:0]             wb_data_q;
  logic [DESC_W-1:0]             res_q;

  lvl_e            lvl;
  logic [VA_W-1:0] rd_addr;
  logic            xfer;
  logic            is_read_st;
  logic            pg_res, pg_wb;
  logic [DESC_W-1:0] pg_new, pg_out;
  logic            unused_bits;

  assign unused_bits = ^{req_addr[SMALL_PAGE_SHIFT-1:0],
                         root_user[WORD_LSB-1:0], root_super[WORD_LSB-1:0]};

  always_comb begin
    unique case (st)
      S_RD_PTR:  lvl = LV_PTR;
      S_RD_PAGE: lvl = LV_PAGE;
      S_RD_IND:  lvl = LV_IND;
      default:   lvl = LV_ROOT;
    endcase
  end

  ptw_index u_index (
    .lvl      (lvl),
    .vpn      (vpn_q),
    .big_page (big_q),
    .base     (base_q),
    .addr     (rd_addr)
  );

  ptw_flags u_flags (
    .pg       (mem_rdata),
    .inh_wp   (wp_q),
    .is_write (wr_q),
    .resident (pg_res),
    .need_wb  (pg_wb),
    .wb_val   (pg_new),
    .res_val  (pg_out)
  );

  assign is_read_st = (st == S_RD_ROOT) || (st == S_RD_PTR) ||
                      (st == S_RD_PAGE) || (st == S_RD_IND);
  assign mem_we    = (st == S_WB_ROOT) || (st == S_WB_PTR) || (st == S_WB_PAGE);
  assign mem_req   = mem_we || is_read_st;
  assign mem_addr  = mem_we ? wb_addr_q : rd_addr;
  assign mem_wdata = wb_data_q;
  assign xfer      = mem_req && mem_ready;

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign desc_out  = res_q;
  assign fault     = ~res_q[B_RES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vpn_q     <= '0;
      wr_q      <= 1'b0;
      big_q     <= 1'b0;
      wp_q      <= 1'b0;
      base_q    <= '0;
      wb_addr_q <= '0;
      wb_data_q <= '0;
      res_q     <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            vpn_q  <= req_addr[VA_W-1:SMALL_PAGE_SHIFT];
            wr_q   <= req_write;
            big_q  <= req_big_page;
            wp_q   <= 1'b0;
            base_q <= req_super ? root_super[DESC_W-1:WORD_LSB]
                                : root_user[DESC_W-1:WORD_LSB];
            st     <= S_RD_ROOT;
          end
        end
        S_RD_ROOT, S_RD_PTR: begin
          if (xfer) begin
            if (mem_err || !mem_rdata[B_LINK]) begin
              res_q <= '0;
              st    <= S_DONE;
            end else begin
              wp_q      <= wp_q | mem_rdata[B_WP];
              base_q    <= mem_rdata[DESC_W-1:WORD_LSB];
              wb_addr_q <= rd_addr;
              wb_data_q <= mem_rdata | USED_MASK;
              if (mem_rdata[B_USED])
                st <= (st == S_RD_ROOT) ? S_RD_PTR : S_RD_PAGE;
              else
                st <= (st == S_RD_ROOT) ? S_WB_ROOT : S_WB_PTR;
            end
          end
        end
        S_WB_ROOT: if (xfer) st <= S_RD_PTR;
        S_WB_PTR:  if (xfer) st <= S_RD_PAGE;
        S_RD_PAGE, S_RD_IND: begin
          if (xfer) begin
            if (mem_err) begin
              res_q <= '0;
              st    <= S_DONE;
            end else if (st == S_RD_PAGE && mem_rdata[B_LINK:B_RES] == IND_CODE) begin
              base_q <= mem_rdata[DESC_W-1:WORD_LSB];
              st     <= S_RD_IND;
            end else if (!pg_res) begin
              res_q <= mem_rdata;
              st    <= S_DONE;
            end else begin
              res_q     <= pg_out;
              wb_addr_q <= rd_addr;
              wb_data_q <= pg_new;
              st        <= pg_wb ? S_WB_PAGE : S_DONE;
            end
          end
        end
        S_WB_PAGE: if (xfer) st <= S_DONE;
        S_DONE:    st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic [DESC_W-1:0] desc_out,
  input logic              mem_req,
  input logic              mem_we,
  input logic [VA_W-1:0]   mem_addr,
  input logic [DESC_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              mem_err
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R13

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !done)); // R1

  AST_TAKE_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1

  AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata))); // R12

  AST_WB_HAS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[B_USED]); // R8

  AST_ERR_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready && mem_err) |=> (done && desc_out == '0)); // R11
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .desc_out  (desc_out),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .mem_err   (mem_err)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid, req_ready, req_super, req_write, req_big_page;
  logic [31:0] req_addr, root_user, root_super;
  logic        done, fault;
  logic [31:0] desc_out;
  logic        mem_req, mem_we, mem_ready, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_super(req_super), .req_write(req_write), .req_big_page(req_big_page),
    .root_user(root_user), .root_super(root_super),
    .done(done), .desc_out(desc_out), .fault(fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  localparam logic [31:0] LA = 32'h1234_5678;
  // LA: root entry offset 0x24, pointer entry offset 0x34,
  // 4 KiB page entry offset 0x14, 8 KiB page entry offset 0x08

  logic [31:0] mem [logic [31:0]];
  logic [63:0] exp_wr[$];
  logic [63:0] e_wr;
  logic [31:0] err_addr;
  logic [31:0] exp_desc;
  int lat, wcnt;
  int nchk = 0, nfail = 0;
  bit pending = 0, got_done = 0;
  string cur_tag;

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %08h expected %08h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // behavioural reference: returns the expected descriptor, queues expected write-backs
  function automatic logic [31:0] model(input logic [31:0] la, input bit sup, input bit wr,
                                        input bit big);
    logic [31:0] a, d, nd;
    bit wp;
    a = ((sup ? root_super : root_user) & 32'hFFFF_FE00) | ((la >> 23) & 32'h1FC);
    if (a == err_addr) return 32'h0;
    d = rd(a);
    if (!d[1]) return 32'h0;
    wp = d[2];
    if (!d[3]) exp_wr.push_back({a, d | 32'h8});
    a = (d & 32'hFFFF_FE00) | ((la >> 16) & 32'h1FC);
    if (a == err_addr) return 32'h0;
    d = rd(a);
    if (!d[1]) return 32'h0;
    wp = wp | d[2];
    if (!d[3]) exp_wr.push_back({a, d | 32'h8});
    a = big ? ((d & 32'hFFFF_FF80) | ((la >> 11) & 32'h7C))
            : ((d & 32'hFFFF_FF00) | ((la >> 10) & 32'hFC));
    if (a == err_addr) return 32'h0;
    d = rd(a);
    if (d[1:0] == 2'b10) begin
      a = d & 32'hFFFF_FFFC;
      if (a == err_addr) return 32'h0;
      d = rd(a);
    end
    if (!d[0]) return d;
    wp = wp | d[2];
    nd = d | 32'h8;
    if (wr && !wp) nd = nd | 32'h10;
    if (nd != d) exp_wr.push_back({a, nd});
    return wp ? (nd | 32'h4) : nd;
  endfunction

  // memory model: answers after lat wait cycles, inputs driven at negedge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0; mem_err <= 1'b0; mem_rdata <= 32'h0; wcnt = 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0; mem_err <= 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready <= 1'b1;
        if (mem_we) begin
          if (exp_wr.size() == 0) begin
            chk(1'b0, {cur_tag, " R10 unexpected write-back addr"}, mem_addr, 32'h0);
          end else begin
            e_wr = exp_wr.pop_front();
            chk(mem_addr == e_wr[63:32], {cur_tag, " R8 R10 write-back addr"},
                mem_addr, e_wr[63:32]);
            chk(mem_wdata == e_wr[31:0], {cur_tag, " R8 R10 write-back data"},
                mem_wdata, e_wr[31:0]);
          end
          mem[mem_addr] = mem_wdata;
        end else begin
          mem_rdata <= rd(mem_addr);
          mem_err   <= (mem_addr == err_addr);
        end
      end else begin
        wcnt++;
      end
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (!pending) begin
        chk(1'b0, "R1 done without an accepted request", desc_out, 32'h0);
      end else begin
        chk(desc_out == exp_desc, {cur_tag, " descriptor"}, desc_out, exp_desc);
        chk(fault == !exp_desc[0], {cur_tag, " R13 fault flag"}, 32'(fault),
            32'(!exp_desc[0]));
        pending = 0;
        got_done = 1;
      end
    end
  end

  task automatic run(input logic [31:0] la, input bit sup, input bit wr, input bit big,
                     input string tag);
    @(negedge clk);
    cur_tag = tag;
    exp_wr.delete();
    exp_desc = model(la, sup, wr, big);
    req_addr = la; req_super = sup; req_write = wr; req_big_page = big;
    got_done = 0; pending = 1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got_done) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R13 done lasts one cycle"}, 32'(done), 32'h0);
    chk(exp_wr.size() == 0, {tag, " R10 missing write-back"}, exp_wr.size(), 32'h0);
  endtask

  task automatic tables(input logic [31:0] rootd, input logic [31:0] ptrd);
    mem.delete();
    mem[32'h0000_1024] = rootd;
    mem[32'h0000_3034] = ptrd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R13 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    req_valid = 0; req_addr = 0; req_super = 0; req_write = 0; req_big_page = 0;
    root_user = 32'h0000_1000; root_super = 32'h0000_2000;
    err_addr = 32'hFFFF_FFFC; lat = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset: ready", 32'(req_ready), 32'h1);
    chk(done == 1'b0, "R13 reset: done low", 32'(done), 32'h0);
    chk(mem_req == 1'b0, "R1 reset: no memory request", 32'(mem_req), 32'h0);

    tables(32'h0000_300A, 32'h0000_400A); mem[32'h4014] = 32'h0ABC_D019;
    run(LA, 0, 0, 0, "R3 R4 read, flags already set");

    lat = 2;
    tables(32'h0000_3002, 32'h0000_4002); mem[32'h4014] = 32'h0ABC_D001;
    run(LA, 0, 0, 0, "R8 R10 read, used flags missing");

    tables(32'h0000_300A, 32'h0000_400A); mem[32'h4014] = 32'h0ABC_D009;
    run(LA, 0, 1, 0, "R10 write sets modified");

    tables(32'h0000_300E, 32'h0000_400A); mem[32'h4014] = 32'h0ABC_D001;
    run(LA, 0, 1, 0, "R9 R10 write under inherited protection");

    lat = 0;
    tables(32'h0000_300A, 32'h0000_400A); mem[32'h4014] = 32'h0ABC_D019;
    run(LA, 0, 1, 0, "R10 write, both flags set, no write-back");

    tables(32'h0000_300A, 32'h0000_400A); mem[32'h4014] = 32'h0ABC_D00D;
    run(LA, 0, 1, 0, "R9 R10 write to own-protected page");

    tables(32'h0000_3008, 32'h0000_400A); mem[32'h4014] = 32'h0ABC_D019;
    run(LA, 0, 0, 0, "R5 invalid root descriptor");

    tables(32'h0000_300A, 32'h0000_4009); mem[32'h4014] = 32'h0ABC_D019;
    run(LA, 0, 0, 0, "R5 invalid pointer descriptor");

    tables(32'h0000_300A, 32'h0000_400A); mem[32'h4014] = 32'h0ABC_D008;
    run(LA, 0, 1, 0, "R7 non-resident page");

    lat = 1;
    tables(32'h0000_300A, 32'h0000_400A); mem[32'h4014] = 32'h0000_5002;
    mem[32'h5000] = 32'h0777_7001;
    run(LA, 0, 0, 0, "R6 indirect page descriptor");
    chk(rd(32'h4014) == 32'h0000_5002, "R6 link entry untouched", rd(32'h4014), 32'h0000_5002);

    tables(32'h0000_300A, 32'h0000_400A);
    mem[32'h4014] = 32'h0111_1019; mem[32'h4008] = 32'h0DDD_E019;
    run(LA, 0, 0, 1, "R4 8 KiB page indexing");
    run(LA, 0, 0, 0, "R4 4 KiB page indexing");

    mem.delete();
    mem[32'h2024] = 32'h0000_300A; mem[32'h3034] = 32'h0000_400A;
    mem[32'h4014] = 32'h0ABC_D019;
    run(LA, 1, 0, 0, "R2 supervisor root");
    run(LA, 0, 0, 0, "R2 user root (empty)");

    tables(32'h0000_300A, 32'h0000_400A); mem[32'h4014] = 32'h0ABC_D019;
    err_addr = 32'h0000_3034;
    run(LA, 0, 0, 0, "R11 error on pointer read");
    err_addr = 32'h0000_4014;
    run(LA, 0, 0, 0, "R11 error on page read");
    err_addr = 32'hFFFF_FFFC;

    lat = 2;
    fork
      run(LA, 0, 0, 0, "R1 walk with request during busy");
      begin
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b0, "R1 not ready while walking", 32'(req_ready), 32'h0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    chk(req_ready == 1'b1 && !pending, "R1 busy request ignored, walker idle",
        32'(req_ready), 32'h1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule